// File: doc/BRIEF.md
# Byte-Block Data Port with Request Handshake

This block gives a processor a narrow data window through which a block of bytes is moved between the host and a small internal buffer, one programmed access at a time. The control side arms the port with a start index, a byte count and a flag that says whether a completion action is pending. The port then raises its data-request line. Each host access of one or two bytes moves bytes at the current buffer pointer, advances the pointer and lowers the remaining count. Host writes also wear down a shared 24-bit transfer counter.

When the remaining count runs out and the completion flag is set, the request line falls and a single-cycle done pulse is issued. The control side reaches the buffer directly through a byte-wide side port, both to preload data that the host will read and to collect data that the host has written. An output gives the number of bytes moved since the last arm.

Top module: `pdma_port`

## Requirements
- R1: After reset, `drq`, `done`, `xfer_cnt`, `remain` and `moved` are all zero.
- R2: A cycle with `arm` high loads the start index and the pointer from `arm_start`, `remain` from `arm_len` and the completion flag from `arm_cb`. In the next cycle `drq` is 1 and `moved` is 0. Arm takes precedence over a host access in the same cycle, and that access then has no effect.
- R3: An access with `acc_size` = 1 moves one byte at the pointer. A write stores `acc_wdata[7:0]`. A read returns the byte on `acc_rdata[7:0]` with `acc_rdata[15:8]` = 0 in the same cycle. The pointer then advances by 1 modulo DEPTH and `remain` drops by 1.
- R4: A write with `acc_size` = 2 stores `acc_wdata[15:8]` at the pointer and `acc_wdata[7:0]` at pointer+1 (modulo DEPTH). The pointer advances by 2 and `remain` drops by 2, saturating at 0.
- R5: A read with `acc_size` = 2 returns the byte at the pointer on `acc_rdata[15:8]` and the byte at pointer+1 on `acc_rdata[7:0]`.
- R6: A host write is ignored when `xfer_cnt` is 0 or `remain` is 0: the buffer, pointer, `remain` and `xfer_cnt` are left unchanged.
- R7: A host read when `remain` is 0 returns 0 and changes nothing.
- R8: An accepted write lowers `xfer_cnt` by the number of bytes in the access, saturating at 0. Reads never change `xfer_cnt`.
- R9: When an access brings `remain` to 0 while the completion flag is set, `drq` is 0 from the next cycle, `done` is 1 for exactly that one cycle, and the flag is cleared.
- R10: When `remain` reaches 0 with the completion flag clear, `drq` stays 1 and `done` stays 0.
- R11: `moved` equals the pointer minus the start index, modulo DEPTH.
- R12: Accesses with `acc_size` 0 or 3 return 0 and change nothing.
- R13: `cnt_ld` loads `xfer_cnt` from `cnt_ld_val` and takes precedence over a same-cycle write decrement. `side_rdata` shows the buffer byte at `side_addr`. A `side_we` write lands in the buffer unless a host write hits the same location in the same cycle, in which case the host write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm the port for a new block |
| arm_start | input | IDX_W | Buffer start index |
| arm_len | input | LEN_W | Byte count of the block |
| arm_cb | input | 1 | Completion action pending |
| cnt_ld | input | 1 | Load the transfer counter |
| cnt_ld_val | input | CNT_W | Transfer counter load value |
| acc_en | input | 1 | Host access this cycle |
| acc_wr | input | 1 | 1 = host write, 0 = host read |
| acc_size | input | 2 | Access size code (1 or 2 bytes) |
| acc_wdata | input | 16 | Host write data |
| acc_rdata | output | 16 | Host read data, same cycle |
| side_we | input | 1 | Control-side buffer write |
| side_addr | input | IDX_W | Control-side buffer address |
| side_wdata | input | 8 | Control-side write byte |
| side_rdata | output | 8 | Control-side read byte |
| drq | output | 1 | Data request |
| done | output | 1 | One-cycle completion pulse |
| xfer_cnt | output | CNT_W | Transfer counter |
| remain | output | LEN_W | Bytes still to move |
| moved | output | IDX_W | Bytes moved since arm |

## Verification
Directed sequences use one-byte writes, two-byte writes that wrap across the top of the buffer, and two-byte reads. They show whether the byte order and the pointer wrap are correct. Corner patterns cover a zero counter, a zero remaining count, a two-byte access when only one byte is left, and illegal size codes. These separate "ignored" from "partially applied", and saturation from underflow. Runs with and without the completion flag show whether the request line and the done pulse follow the flag and not the count alone. A seeded random mix then interleaves arms, counter loads, side-port writes and every access kind, which exposes precedence faults between arm, load and access.

// File: rtl/pdma_port.sv
module pdma_port #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 24,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [IDX_W-1:0] arm_start,
  input  logic [LEN_W-1:0] arm_len,
  input  logic             arm_cb,
  input  logic             cnt_ld,
  input  logic [CNT_W-1:0] cnt_ld_val,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [1:0]       acc_size,
  input  logic [15:0]      acc_wdata,
  output logic [15:0]      acc_rdata,
  input  logic             side_we,
  input  logic [IDX_W-1:0] side_addr,
  input  logic [7:0]       side_wdata,
  output logic [7:0]       side_rdata,
  output logic             drq,
  output logic             done,
  output logic [CNT_W-1:0] xfer_cnt,
  output logic [LEN_W-1:0] remain,
  output logic [IDX_W-1:0] moved
);

  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] start_q, cur_q, nxt;
  logic             cb_q;

  logic             sz1, sz2, sz_ok, rd_go, wr_go, go, fin;
  logic [LEN_W-1:0] step_len, rem_nxt;
  logic [CNT_W-1:0] step_cnt, cnt_nxt;

  assign sz1   = (acc_size == 2'd1);
  assign sz2   = (acc_size == 2'd2);
  assign sz_ok = sz1 | sz2;

  assign rd_go = acc_en & ~acc_wr & sz_ok & (remain != '0);
  assign wr_go = acc_en &  acc_wr & sz_ok & (remain != '0) & (xfer_cnt != '0);
  assign go    = (rd_go | wr_go) & ~arm;

  assign nxt = (cur_q == IDX_W'(DEPTH - 1)) ? '0 : cur_q + 1'b1;

  assign step_len = sz2 ? LEN_W'(2) : LEN_W'(1);
  assign step_cnt = sz2 ? CNT_W'(2) : CNT_W'(1);
  assign rem_nxt  = (remain > step_len) ? remain - step_len : '0;
  assign cnt_nxt  = (xfer_cnt > step_cnt) ? xfer_cnt - step_cnt : '0;
  assign fin      = go & (rem_nxt == '0) & cb_q;

  assign acc_rdata  = !rd_go ? 16'h0 :
                      sz2    ? {mem[cur_q], mem[nxt]} : {8'h0, mem[cur_q]};
  assign side_rdata = mem[side_addr];
  assign moved      = cur_q - start_q;

  always_ff @(posedge clk) begin
    if (side_we) mem[side_addr] <= side_wdata;
    if (go && acc_wr) begin
      if (sz2) begin
        mem[cur_q] <= acc_wdata[15:8];
        mem[nxt]   <= acc_wdata[7:0];
      end else begin
        mem[cur_q] <= acc_wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cur_q   <= '0;
      remain  <= '0;
      cb_q    <= 1'b0;
      drq     <= 1'b0;
      done    <= 1'b0;
    end else if (arm) begin
      start_q <= arm_start;
      cur_q   <= arm_start;
      remain  <= arm_len;
      cb_q    <= arm_cb;
      drq     <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= fin;
      if (go) begin
        cur_q  <= sz2 ? nxt + 1'b1 - ((nxt == IDX_W'(DEPTH - 1)) ? IDX_W'(DEPTH) : '0) : nxt;
        remain <= rem_nxt;
      end
      if (fin) begin
        drq  <= 1'b0;
        cb_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            xfer_cnt <= '0;
    else if (cnt_ld)       xfer_cnt <= cnt_ld_val;
    else if (go && acc_wr) xfer_cnt <= cnt_nxt;
  end

endmodule

module pdma_port_chk #(
  parameter int CNT_W = 24,
  parameter int IDX_W = 5,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             cnt_ld,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [1:0]       acc_size,
  input logic [15:0]      acc_rdata,
  input logic             drq,
  input logic             done,
  input logic [CNT_W-1:0] xfer_cnt,
  input logic [LEN_W-1:0] remain,
  input logic [IDX_W-1:0] moved
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_DONE_DRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n) done |-> !drq); // R9
  AST_ARM_LOADS: assert property (@(posedge clk) disable iff (!rst_n) arm |=> (drq && moved == '0)); // R2
  AST_RD_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && remain == '0) |-> acc_rdata == 16'h0); // R7
  AST_RD_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr && !cnt_ld) |=> $stable(xfer_cnt)); // R8
  AST_WR_NO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && xfer_cnt == '0 && !arm) |=> $stable(remain)); // R6
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && (acc_size == 2'd0 || acc_size == 2'd3) && !arm && !cnt_ld)
      |=> ($stable(remain) && $stable(xfer_cnt) && $stable(moved))); // R12

endmodule

bind pdma_port pdma_port_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/pdma_port_tb.sv
module pdma_port_tb;
  localparam int DEPTH = 32;
  localparam int CNT_W = 24;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic arm = 0, arm_cb = 0, cnt_ld = 0, acc_en = 0, acc_wr = 0, side_we = 0;
  logic [IDX_W-1:0] arm_start = '0, side_addr = '0;
  logic [LEN_W-1:0] arm_len = '0;
  logic [CNT_W-1:0] cnt_ld_val = '0;
  logic [1:0] acc_size = '0;
  logic [15:0] acc_wdata = '0;
  logic [7:0] side_wdata = '0;
  logic [15:0] acc_rdata;
  logic [7:0] side_rdata;
  logic drq, done;
  logic [CNT_W-1:0] xfer_cnt;
  logic [LEN_W-1:0] remain;
  logic [IDX_W-1:0] moved;

  pdma_port #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (.*);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;

  logic [7:0] m_mem [DEPTH];
  int m_start = 0, m_cur = 0, m_rem = 0, m_cnt = 0;
  bit m_cb = 0, m_drq = 0, m_done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd();
    bit s2 = (acc_size == 2'd2);
    if (!(acc_en && !acc_wr && (acc_size == 2'd1 || s2) && m_rem != 0)) return 0;
    if (s2) return {m_mem[m_cur], m_mem[(m_cur + 1) % DEPTH]};
    return {8'h0, m_mem[m_cur]};
  endfunction

  task automatic clear_in();
    arm = 0; arm_cb = 0; cnt_ld = 0; acc_en = 0; acc_wr = 0; side_we = 0;
    acc_size = 0; acc_wdata = 0;
  endtask

  task automatic tick();
    bit s2, ok_sz, go, fin;
    int n, nrem;
    #1;
    chk(acc_rdata == 16'(exp_rd()),
        (m_rem == 0) ? "R7" : (acc_size == 2'd2) ? "R5" : (acc_size == 2'd1) ? "R3" : "R12",
        acc_rdata, exp_rd());
    chk(side_rdata == m_mem[side_addr], "R13", side_rdata, m_mem[side_addr]);
    s2 = (acc_size == 2'd2);
    ok_sz = (acc_size == 2'd1) || s2;
    n = s2 ? 2 : 1;
    go = acc_en && ok_sz && m_rem != 0 && (!acc_wr || m_cnt != 0) && !arm;
    nrem = (m_rem > n) ? m_rem - n : 0;
    fin = go && nrem == 0 && m_cb;
    if (side_we) m_mem[side_addr] = side_wdata;
    if (go && acc_wr) begin
      if (s2) begin
        m_mem[m_cur] = acc_wdata[15:8];
        m_mem[(m_cur + 1) % DEPTH] = acc_wdata[7:0];
      end else m_mem[m_cur] = acc_wdata[7:0];
    end
    if (cnt_ld) m_cnt = int'(cnt_ld_val);
    else if (go && acc_wr) m_cnt = (m_cnt > n) ? m_cnt - n : 0;
    if (arm) begin
      m_start = arm_start; m_cur = arm_start; m_rem = arm_len;
      m_cb = arm_cb; m_drq = 1; m_done = 0;
    end else begin
      m_done = fin;
      if (go) begin m_cur = (m_cur + n) % DEPTH; m_rem = nrem; end
      if (fin) begin m_drq = 0; m_cb = 0; end
    end
    @(negedge clk);
    chk(drq == m_drq, "R9/R10 drq", drq, m_drq);
    chk(done == m_done, "R9 done", done, m_done);
    chk(xfer_cnt == CNT_W'(m_cnt), "R8 counter", xfer_cnt, m_cnt);
    chk(remain == LEN_W'(m_rem), "R3 remain", remain, m_rem);
    chk(moved == IDX_W'((m_cur - m_start + DEPTH) % DEPTH), "R11 moved",
        moved, (m_cur - m_start + DEPTH) % DEPTH);
    clear_in();
  endtask

  task automatic do_arm(int st, int ln, bit cb);
    arm = 1; arm_start = IDX_W'(st); arm_len = LEN_W'(ln); arm_cb = cb; tick();
  endtask
  task automatic do_cnt(int v);
    cnt_ld = 1; cnt_ld_val = CNT_W'(v); tick();
  endtask
  task automatic do_acc(bit wr, int sz, int d);
    acc_en = 1; acc_wr = wr; acc_size = 2'(sz); acc_wdata = 16'(d); tick();
  endtask
  task automatic peek(int a, string req);
    side_addr = IDX_W'(a); #1;
    chk(side_rdata == m_mem[a], req, side_rdata, m_mem[a]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(drq == 0 && done == 0, "R1 flags", {drq, done}, 0);
    chk(xfer_cnt == 0 && remain == 0 && moved == 0, "R1 state", xfer_cnt, 0);
    rst_n = 1;
    for (int i = 0; i < DEPTH; i++) begin
      side_we = 1; side_addr = IDX_W'(i); side_wdata = 8'(i * 7 + 3); tick();
    end
    do_cnt(5);
    chk(xfer_cnt == 5, "R13 load", xfer_cnt, 5);
    do_arm(30, 4, 1);
    chk(drq == 1 && moved == 0 && remain == 4, "R2 arm", {drq, moved}, 'h100);
    do_acc(1, 1, 16'h77A5);
    peek(30, "R3 byte");
    chk(xfer_cnt == 4, "R8 dec1", xfer_cnt, 4);
    do_acc(1, 2, 16'h1234);
    peek(31, "R4 high byte");
    peek(0, "R4 low byte wrap");
    chk(m_mem[31] == 8'h12 && m_mem[0] == 8'h34, "R4 model", m_mem[31], 8'h12);
    chk(moved == 3, "R11 wrap", moved, 3);
    do_acc(1, 3, 16'hFFFF);
    chk(remain == 1, "R12 bad size", remain, 1);
    do_acc(1, 1, 16'h00C3);
    chk(done == 1 && drq == 0, "R9 finish", {done, drq}, 'b10);
    tick();
    chk(done == 0, "R9 one cycle", done, 0);
    do_acc(1, 1, 16'h0099);
    peek(1, "R6 len zero");
    do_acc(0, 2, 0);
    do_arm(10, 3, 0);
    do_cnt(0);
    do_acc(1, 1, 16'h00EE);
    chk(remain == 3, "R6 cnt zero", remain, 3);
    peek(10, "R6 buffer kept");
    acc_en = 1; acc_wr = 0; acc_size = 2; #1;
    chk(acc_rdata == {m_mem[10], m_mem[11]}, "R5 order", acc_rdata, {m_mem[10], m_mem[11]});
    tick();
    do_acc(0, 1, 0);
    chk(drq == 1 && done == 0 && remain == 0, "R10 no flag", {drq, done}, 'b10);
    do_arm(20, 1, 1);
    do_cnt(1);
    do_acc(1, 2, 16'hBEEF);
    chk(remain == 0 && xfer_cnt == 0, "R4 saturate", remain, 0);
    do_arm(5, 2, 1);
    acc_en = 1; acc_wr = 1; acc_size = 1; acc_wdata = 16'h55;
    arm = 1; arm_start = 8; arm_len = 2; arm_cb = 1; tick();
    chk(moved == 0 && remain == 2, "R2 arm wins", moved, 0);

    void'($urandom(32'd20240611));
    for (int k = 0; k < 4000; k++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 7) begin
        arm = 1; arm_start = IDX_W'($urandom_range(0, DEPTH - 1));
        arm_len = LEN_W'($urandom_range(0, DEPTH)); arm_cb = 1'($urandom_range(0, 1));
      end
      if (r >= 7 && r < 12) begin
        cnt_ld = 1; cnt_ld_val = CNT_W'($urandom_range(0, 8));
      end
      if ($urandom_range(0, 9) < 7) begin
        acc_en = 1; acc_wr = 1'($urandom_range(0, 1));
        acc_size = 2'($urandom_range(0, 3)); acc_wdata = 16'($urandom);
      end
      side_addr = IDX_W'($urandom_range(0, DEPTH - 1));
      if ($urandom_range(0, 9) == 0) begin
        side_we = 1; side_wdata = 8'($urandom);
      end
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule